// File: doc/BRIEF.md
# Lockable Single-Channel Pulse-Width Modulator

This block generates one pulse-width modulated output from a free-running counter. It has a small register bus with address, write data, write strobe, read strobe and registered read data. Software programs a period length and an active-phase length, both counted in input clock cycles, plus a control word. The control word holds the run bits, the levels of the active and idle phases, and a lock bit. The waveform is left-aligned: every period starts with its active phase.

Programmed values are not used directly. A set of working registers drives the counter and the output. The working registers copy the programmed values only when the counter is stopped or at a period boundary, so a period is never cut short. While the lock bit is set, software can rewrite period, duty and polarity without touching the running waveform. When the lock is cleared, all three take effect together at the next period start.

Top module: `pwm_lock_timer`

## Requirements
- R1: After reset every register reads zero, the counter is stopped at zero and the output is low.
- R2: The counter is at address 0x0, period at 0x4, duty at 0x8 and control at 0xC. Period, duty and control read back the last 32-bit value written. Read data appears in the cycle after the read strobe. Other addresses read zero and ignore writes, and writes to the counter address are ignored.
- R3: The counter runs only when control bit 0 (enable) and bit 1 (continuous) are both set. Otherwise the counter holds zero and the output sits at the idle level.
- R4: The counter register reads the live count sampled at the read strobe. A running count goes 0, 1, … period−1 and then wraps to 0. With a period of 0 or 1 it stays at 0.
- R5: While running, the output is at the active level (control bit 3) while the count is below duty, and at the idle level (control bit 4) otherwise. Duty 0 gives a fully idle output, and duty at or above period gives a fully active output.
- R6: With the lock clear, new period, duty and polarity values written during a running period take effect only at the next wrap, never in mid-period.
- R7: While control bit 6 (lock) is set, period, duty and polarity writes are stored and read back but leave the waveform unchanged.
- R8: After the lock is cleared, the stored period, duty and polarity become effective together in the first cycle of the next period.
- R9: While stopped and unlocked, the working settings follow the programmed ones every cycle. The first period after enabling therefore uses the values present before the enabling write.
- R10: One cycle after the run bits are cleared, the counter is zero and the output takes the idle level. From the following cycle on, the output follows the newly written bit 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for counter and registers |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | DW | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DW | Registered read data |
| pwm_out | output | 1 | Modulated output |

## Verification
The hard case is a configuration write, especially the write that clears the lock, that lands on the same clock edge as a counter wrap. The two updates then meet in one cycle, and it must be decided whether the new values apply to the period now starting or to the one after. The bench sweeps the write across every phase of a running period, both locked and unlocked. It compares the output and the live count cycle by cycle with an arithmetic model written from the requirements, so a boundary that slips by one cycle shows up as a level mismatch.

// File: rtl/pwm_lock_pkg.sv
package pwm_lock_pkg;
  // Register byte offsets
  localparam int OFS_COUNT  = 'h0;
  localparam int OFS_PERIOD = 'h4;
  localparam int OFS_DUTY   = 'h8;
  localparam int OFS_CTRL   = 'hC;
  // Control word bit positions
  localparam int B_ENABLE   = 0;
  localparam int B_CONT     = 1;
  localparam int B_ACT_HI   = 3;
  localparam int B_IDLE_HI  = 4;
  localparam int B_LOCK     = 6;
endpackage

// File: rtl/pwm_lock_regs.sv
module pwm_lock_regs
  import pwm_lock_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          we,
  input  logic          re,
  input  logic [DW-1:0] live_cnt,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] prog_period,
  output logic [DW-1:0] prog_duty,
  output logic [DW-1:0] ctrl
);

  logic          sel_cnt, sel_per, sel_dut, sel_ctl;
  logic          per_en, dut_en, ctl_en;
  logic [DW-1:0] rdata_d;

  always_comb begin
    sel_cnt = (addr == AW'(OFS_COUNT));
    sel_per = (addr == AW'(OFS_PERIOD));
    sel_dut = (addr == AW'(OFS_DUTY));
    sel_ctl = (addr == AW'(OFS_CTRL));
    per_en  = we && sel_per;
    dut_en  = we && sel_dut;
    ctl_en  = we && sel_ctl;
    rdata_d = '0;
    if (sel_cnt) rdata_d = live_cnt;
    if (sel_per) rdata_d = prog_period;
    if (sel_dut) rdata_d = prog_duty;
    if (sel_ctl) rdata_d = ctrl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_period <= '0;
      prog_duty   <= '0;
      ctrl        <= '0;
      rdata       <= '0;
    end else begin
      if (per_en) prog_period <= wdata;
      if (dut_en) prog_duty   <= wdata;
      if (ctl_en) ctrl        <= wdata;
      if (re)     rdata       <= rdata_d;
    end
  end

endmodule

// File: rtl/pwm_lock_shadow.sv
module pwm_lock_shadow #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] prog_period,
  input  logic [DW-1:0] prog_duty,
  input  logic          prog_act,
  input  logic          prog_idle,
  input  logic          lock,
  input  logic          run,
  input  logic          wrap,
  output logic [DW-1:0] eff_period,
  output logic [DW-1:0] eff_duty,
  output logic          eff_act,
  output logic          eff_idle
);

  logic load_en;

  // Copy only when stopped or at a boundary, and never while locked
  always_comb begin
    load_en = !lock && (!run || wrap);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_period <= '0;
      eff_duty   <= '0;
      eff_act    <= 1'b0;
      eff_idle   <= 1'b0;
    end else if (load_en) begin
      eff_period <= prog_period;
      eff_duty   <= prog_duty;
      eff_act    <= prog_act;
      eff_idle   <= prog_idle;
    end
  end

endmodule

// File: rtl/pwm_lock_engine.sv
module pwm_lock_engine #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [DW-1:0] eff_period,
  input  logic [DW-1:0] eff_duty,
  input  logic          eff_act,
  input  logic          eff_idle,
  output logic [DW-1:0] cnt,
  output logic          wrap,
  output logic          pwm_out
);

  logic [DW-1:0] cnt_d;
  logic          last;
  logic          cnt_en;

  always_comb begin
    last   = (eff_period <= DW'(1)) || (cnt == eff_period - DW'(1));
    wrap   = run && last;
    cnt_en = run || (cnt != '0);
    if (!run)      cnt_d = '0;
    else if (last) cnt_d = '0;
    else           cnt_d = cnt + DW'(1);
    if (run && (cnt < eff_duty)) pwm_out = eff_act;
    else                         pwm_out = eff_idle;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end

endmodule

// File: rtl/pwm_lock_timer.sv
module pwm_lock_timer
  import pwm_lock_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_we,
  input  logic          bus_re,
  output logic [DW-1:0] bus_rdata,
  output logic          pwm_out
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   core_rst_n;
  logic [DW-1:0]          prog_period, prog_duty, ctrl, cnt;
  logic [DW-1:0]          eff_period, eff_duty;
  logic                   eff_act, eff_idle;
  logic                   run, lock, wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end

  always_comb begin
    core_rst_n = rst_pipe[SYNC_STAGES-1];
    run        = ctrl[B_ENABLE] && ctrl[B_CONT];
    lock       = ctrl[B_LOCK];
  end

  pwm_lock_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(core_rst_n), .addr(bus_addr), .wdata(bus_wdata),
    .we(bus_we), .re(bus_re), .live_cnt(cnt), .rdata(bus_rdata),
    .prog_period(prog_period), .prog_duty(prog_duty), .ctrl(ctrl)
  );

  pwm_lock_shadow #(.DW(DW)) u_shadow (
    .clk(clk), .rst_n(core_rst_n), .prog_period(prog_period),
    .prog_duty(prog_duty), .prog_act(ctrl[B_ACT_HI]),
    .prog_idle(ctrl[B_IDLE_HI]), .lock(lock), .run(run), .wrap(wrap),
    .eff_period(eff_period), .eff_duty(eff_duty),
    .eff_act(eff_act), .eff_idle(eff_idle)
  );

  pwm_lock_engine #(.DW(DW)) u_engine (
    .clk(clk), .rst_n(core_rst_n), .run(run), .eff_period(eff_period),
    .eff_duty(eff_duty), .eff_act(eff_act), .eff_idle(eff_idle),
    .cnt(cnt), .wrap(wrap), .pwm_out(pwm_out)
  );

endmodule

// File: rtl/pwm_lock_timer_chk.sv
module pwm_lock_timer_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          lock,
  input logic          wrap,
  input logic [DW-1:0] cnt,
  input logic [DW-1:0] ctrl,
  input logic [DW-1:0] eff_period,
  input logic [DW-1:0] eff_duty,
  input logic          eff_act,
  input logic          pwm_out
);

  // R3
  stopped_count_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);

  // R10
  stopped_idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !lock && $stable(ctrl)) |-> pwm_out == ctrl[4]);

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> cnt == $past(cnt) + DW'(1));

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && eff_period > DW'(1)) |-> cnt < eff_period);

  // R7
  lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> ($stable(eff_period) && $stable(eff_duty) && $stable(eff_act)));

  // R6
  mid_period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> ($stable(eff_period) && $stable(eff_duty) && $stable(eff_act)));

endmodule

bind pwm_lock_timer pwm_lock_timer_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .lock(lock), .wrap(wrap),
  .cnt(cnt), .ctrl(ctrl), .eff_period(eff_period), .eff_duty(eff_duty),
  .eff_act(eff_act), .pwm_out(pwm_out)
);

// File: tb/test_pwm_lock_timer.sv
`timescale 1ns/1ps
module test_pwm_lock_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        pwm_out;

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";
  string rd_req = "R1";

  // reference state built from the requirements
  logic [31:0] m_per = '0, m_dut = '0, m_ctl = '0, m_cnt = '0;
  logic [31:0] e_per = '0, e_dut = '0;
  logic        e_act = 1'b0, e_idle = 1'b0;

  always #2 clk = ~clk;

  pwm_lock_timer i_pwm_lock_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // One clock cycle: bus signals already driven at the falling edge
  task automatic tick();
    logic        run, lock, last, upd, rd, exp_o;
    logic [31:0] n_cnt, exp_rd;
    run   = m_ctl[0] && m_ctl[1];
    lock  = m_ctl[6];
    last  = (e_per <= 32'd1) || (m_cnt == e_per - 32'd1);
    upd   = !lock && (!run || (run && last));
    n_cnt = run ? (last ? 32'd0 : m_cnt + 32'd1) : 32'd0;
    rd    = bus_re;
    case (bus_addr)
      4'h0: exp_rd = m_cnt;
      4'h4: exp_rd = m_per;
      4'h8: exp_rd = m_dut;
      4'hC: exp_rd = m_ctl;
      default: exp_rd = 32'd0;
    endcase
    if (upd) begin
      e_per = m_per; e_dut = m_dut; e_act = m_ctl[3]; e_idle = m_ctl[4];
    end
    if (bus_we) begin
      case (bus_addr)
        4'h4: m_per = bus_wdata;
        4'h8: m_dut = bus_wdata;
        4'hC: m_ctl = bus_wdata;
        default: ;
      endcase
    end
    m_cnt = n_cnt;
    @(negedge clk);
    run   = m_ctl[0] && m_ctl[1];
    exp_o = (run && (m_cnt < e_dut)) ? e_act : e_idle;
    check(pwm_out === exp_o, cur_req, {31'd0, pwm_out}, {31'd0, exp_o});
    if (rd) check(bus_rdata === exp_rd, rd_req, bus_rdata, exp_rd);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    tick();
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a);
    bus_addr = a; bus_re = 1'b1;
    tick();
    bus_re = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic watch_count(input int n);
    bus_addr = 4'h0; bus_re = 1'b1;
    for (int i = 0; i < n; i++) tick();
    bus_re = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset values
    cur_req = "R1"; rd_req = "R1";
    check(pwm_out === 1'b0, "R1", {31'd0, pwm_out}, 32'd0);
    rd(4'h0); rd(4'h4); rd(4'h8); rd(4'hC);

    // R2: map, readback, unmapped and counter writes ignored
    cur_req = "R2"; rd_req = "R2";
    wr(4'h4, 32'hDEAD_BEEF); rd(4'h4);
    wr(4'h8, 32'h1234_5678); rd(4'h8);
    wr(4'hC, 32'hFFFF_FFBC); rd(4'hC);
    wr(4'h2, 32'hFFFF_FFFF); rd(4'h2);
    wr(4'h0, 32'h0000_00AA); rd(4'h0);
    wr(4'hC, 32'h0); rd(4'hC);

    // R4/R5/R9: sweep polarity, period and duty
    for (int pol = 0; pol < 4; pol++) begin
      for (int p = 0; p < 6; p++) begin
        for (int d = 0; d < 7; d++) begin
          cur_req = "R9"; rd_req = "R4";
          wr(4'hC, 32'(pol) << 3);
          wr(4'h4, 32'(p));
          wr(4'h8, 32'(d));
          wr(4'hC, (32'(pol) << 3) | 32'h3);
          cur_req = "R5";
          watch_count(2 * p + 3);
        end
      end
    end

    // R3: only one of the two run bits set
    cur_req = "R3"; rd_req = "R3";
    wr(4'hC, 32'h18); wr(4'h4, 32'd4); wr(4'h8, 32'd2);
    wr(4'hC, 32'h19); watch_count(6);
    wr(4'hC, 32'h1A); watch_count(6);

    // R6: unlocked rewrite at every phase of a running period
    for (int k = 0; k < 4; k++) begin
      cur_req = "R6"; rd_req = "R6";
      wr(4'hC, 32'h08); wr(4'h4, 32'd4); wr(4'h8, 32'd1);
      wr(4'hC, 32'h0B);
      idle(k);
      wr(4'h4, 32'd6); wr(4'h8, 32'd3); wr(4'hC, 32'h13);
      watch_count(14);
    end

    // R7/R8: locked rewrite, then unlock at every phase
    for (int k = 0; k < 5; k++) begin
      cur_req = "R7"; rd_req = "R7";
      wr(4'hC, 32'h08); wr(4'h4, 32'd5); wr(4'h8, 32'd2);
      wr(4'hC, 32'h0B);
      wr(4'hC, 32'h4B);
      wr(4'h4, 32'd3); wr(4'h8, 32'd1); wr(4'hC, 32'h53);
      idle(11);
      rd(4'h4); rd(4'h8);
      idle(k);
      cur_req = "R8"; rd_req = "R8";
      wr(4'hC, 32'h13);
      watch_count(10);
    end

    // R10: stop while running, idle level switches
    cur_req = "R10"; rd_req = "R10";
    wr(4'hC, 32'h00);
    watch_count(4);
    wr(4'hC, 32'h10);
    idle(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule